// File: doc/BRIEF.md
# Sequential Dial Combination Lock

A synchronous state machine that releases a lock only when three dial operations arrive in the right order. Each operation carries a direction bit (1 = turned right, 0 = turned left) and a 6-bit dial value. A one-cycle strobe marks the cycle in which the operation is complete. The built-in combination is right 13, then left 22, then right 3. The same values in another order, or with another direction, do not open it.

Progress is held in a two-bit state: start, first step done, first two steps done, and open. A strobed operation that does not fit the next step sends the lock back to the start. The exception is an operation equal to the first step, which counts as a fresh first step. Once open, the lock ignores the dial until a relock pulse or a synchronous reset closes it. The `unlocked` output comes straight from a flop and is high only while the machine is in the open state.

Top module: `seq_dial_lock`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), the lock is in the start state and `unlocked` is 0. This also holds when reset arrives mid-sequence or while the lock is open.
- R2: Strobed operations right 13, left 22, right 3 (`op_dir` 1 = right, 0 = left), given back to back from the start state, raise `unlocked` in the cycle after the third strobe's clock edge.
- R3: `unlocked` is high only when the machine is in the open state. It stays 0 after any partial sequence.
- R4: An operation presented with `op_valid` low has no effect on the state.
- R5: From a closed state, a strobed operation that is neither the expected next step nor right 13 returns the lock to the start state. The full sequence is then needed again.
- R6: A strobed right 13 in any closed state puts the lock in the first-step-done state. Left 22 followed by right 3 then opens it.
- R7: Direction is part of each step. The right value with the wrong direction counts as a wrong operation.
- R8: While open, strobed operations are ignored and `unlocked` stays 1.
- R9: A `relock` pulse returns the lock to the start state with `unlocked` 0 from the next cycle. It takes priority over a strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe: operation complete |
| op_dir | input | 1 | Direction of the operation, 1 = right, 0 = left |
| op_value | input | 6 | Dial value of the operation |
| relock | input | 1 | Close the lock and restart the sequence |
| unlocked | output | 1 | Registered open indication |

## Verification
The stimulus includes the correct sequence and a sequence whose values are right but whose first step has the wrong direction. It also includes a wrong third direction. Together these show that direction is compared at every step and that value alone is not enough. Repeated and late right-13 operations separate a restart into the first-step state from a fall back to the start. Unstrobed operations and a relock in the same cycle as a strobe show which input wins. Reset in the middle of a sequence shows that partial progress is discarded.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

  localparam int NUM_STEPS = 3;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_ONE  = 2'd1,
    LK_TWO  = 2'd2,
    LK_OPEN = 2'd3
  } lock_state_e;

endpackage

// File: rtl/dial_step_match.sv
module dial_step_match
  import dial_lock_pkg::*;
#(
  parameter int                         VAL_W     = 6,
  parameter logic [NUM_STEPS-1:0]       STEP_DIRS = 3'b101,
  parameter logic [NUM_STEPS*VAL_W-1:0] STEP_VALS = {6'd3, 6'd22, 6'd13}
) (
  input  logic                 op_valid,
  input  logic                 op_dir,
  input  logic [VAL_W-1:0]     op_value,
  output logic [NUM_STEPS-1:0] step_hit
);

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
    always_comb begin
      step_hit[i] = op_valid && (op_dir == STEP_DIRS[i]) &&
                    (op_value == STEP_VALS[i*VAL_W +: VAL_W]);
    end
  end

endmodule

// File: rtl/dial_lock_next.sv
module dial_lock_next
  import dial_lock_pkg::*;
(
  input  lock_state_e          cur_state,
  input  logic                 op_valid,
  input  logic                 relock,
  input  logic [NUM_STEPS-1:0] step_hit,
  output lock_state_e          nxt_state
);

  always_comb begin
    nxt_state = cur_state;
    if (relock) begin
      nxt_state = LK_IDLE;
    end else if (op_valid && cur_state != LK_OPEN) begin
      case (cur_state)
        LK_IDLE: nxt_state = step_hit[0] ? LK_ONE : LK_IDLE;
        LK_ONE:  nxt_state = step_hit[1] ? LK_TWO :
                             (step_hit[0] ? LK_ONE : LK_IDLE);
        LK_TWO:  nxt_state = step_hit[2] ? LK_OPEN :
                             (step_hit[0] ? LK_ONE : LK_IDLE);
        default: nxt_state = LK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dial_lock_state_reg.sv
module dial_lock_state_reg
  import dial_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e nxt_state,
  output lock_state_e cur_state,
  output logic        open_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state <= LK_IDLE;
      open_q    <= 1'b0;
    end else begin
      cur_state <= nxt_state;
      open_q    <= (nxt_state == LK_OPEN);
    end
  end

endmodule

// File: rtl/seq_dial_lock.sv
module seq_dial_lock
  import dial_lock_pkg::*;
#(
  parameter int                         VAL_W     = 6,
  parameter logic [NUM_STEPS-1:0]       STEP_DIRS = 3'b101,
  parameter logic [NUM_STEPS*VAL_W-1:0] STEP_VALS = {6'd3, 6'd22, 6'd13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic             op_dir,
  input  logic [VAL_W-1:0] op_value,
  input  logic             relock,
  output logic             unlocked
);

  logic [NUM_STEPS-1:0] step_hit;
  lock_state_e          state_q;
  lock_state_e          state_d;

  dial_step_match #(
    .VAL_W    (VAL_W),
    .STEP_DIRS(STEP_DIRS),
    .STEP_VALS(STEP_VALS)
  ) match_i (
    .op_valid(op_valid),
    .op_dir  (op_dir),
    .op_value(op_value),
    .step_hit(step_hit)
  );

  dial_lock_next next_i (
    .cur_state(state_q),
    .op_valid (op_valid),
    .relock   (relock),
    .step_hit (step_hit),
    .nxt_state(state_d)
  );

  dial_lock_state_reg reg_i (
    .clk      (clk),
    .rst      (rst),
    .nxt_state(state_d),
    .cur_state(state_q),
    .open_q   (unlocked)
  );

endmodule

// File: rtl/dial_lock_checker.sv
module dial_lock_checker
  import dial_lock_pkg::*;
#(
  parameter int                         VAL_W     = 6,
  parameter logic [NUM_STEPS-1:0]       STEP_DIRS = 3'b101,
  parameter logic [NUM_STEPS*VAL_W-1:0] STEP_VALS = {6'd3, 6'd22, 6'd13}
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_dir,
  input logic [VAL_W-1:0] op_value,
  input logic             relock,
  input logic [1:0]       state_q,
  input logic             unlocked
);

  logic is_first, is_second, is_third;
  assign is_first  = (op_dir == STEP_DIRS[0]) && (op_value == STEP_VALS[0 +: VAL_W]);
  assign is_second = (op_dir == STEP_DIRS[1]) && (op_value == STEP_VALS[VAL_W +: VAL_W]);
  assign is_third  = (op_dir == STEP_DIRS[2]) && (op_value == STEP_VALS[2*VAL_W +: VAL_W]);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (state_q == LK_IDLE) && !unlocked);

  assert_open_after_third_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !relock && state_q == LK_TWO && is_third) |=> unlocked);

  assert_out_tracks_state_R3: assert property (@(posedge clk) disable iff (rst)
    unlocked == (state_q == LK_OPEN));

  assert_no_strobe_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !relock) |=> $stable(state_q));

  assert_wrong_second_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !relock && state_q == LK_ONE && !is_second && !is_first)
      |=> state_q == LK_IDLE);

  assert_first_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !relock && state_q != LK_OPEN && is_first) |=> state_q == LK_ONE);

  assert_open_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == LK_OPEN && !relock) |=> unlocked);

  assert_relock_closes_R9: assert property (@(posedge clk) disable iff (rst)
    relock |=> (state_q == LK_IDLE) && !unlocked);

endmodule

bind seq_dial_lock dial_lock_checker #(
  .VAL_W    (VAL_W),
  .STEP_DIRS(STEP_DIRS),
  .STEP_VALS(STEP_VALS)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op_valid(op_valid),
  .op_dir  (op_dir),
  .op_value(op_value),
  .relock  (relock),
  .state_q (state_q),
  .unlocked(unlocked)
);

// File: tb/seq_dial_lock_tb_top.sv
module seq_dial_lock_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       op_valid;
  logic       op_dir;
  logic [5:0] op_value;
  logic       relock;
  logic       unlocked;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  seq_dial_lock dut_i (
    .clk     (clk),
    .rst     (rst),
    .op_valid(op_valid),
    .op_dir  (op_dir),
    .op_value(op_value),
    .relock  (relock),
    .unlocked(unlocked)
  );

  // vector: {valid, relock, dir(1=right), value[5:0], expected unlocked}
  localparam int NV = 32;
  localparam logic [9:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,6'd13,1'b0},  //  0 R2 right 13
    {1'b1,1'b0,1'b0,6'd22,1'b0},  //  1 R2 R3 left 22, still closed
    {1'b1,1'b0,1'b1,6'd3 ,1'b1},  //  2 R2 right 3 opens
    {1'b1,1'b0,1'b1,6'd13,1'b1},  //  3 R8 ignored while open
    {1'b1,1'b0,1'b0,6'd5 ,1'b1},  //  4 R8 ignored while open
    {1'b0,1'b1,1'b0,6'd0 ,1'b0},  //  5 R9 relock
    {1'b0,1'b0,1'b1,6'd13,1'b0},  //  6 R4 unstrobed right 13
    {1'b1,1'b0,1'b0,6'd22,1'b0},  //  7 R4
    {1'b1,1'b0,1'b1,6'd3 ,1'b0},  //  8 R4 must not open
    {1'b1,1'b0,1'b1,6'd13,1'b0},  //  9
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 10
    {1'b1,1'b0,1'b0,6'd3 ,1'b0},  // 11 R7 wrong direction third
    {1'b1,1'b0,1'b1,6'd3 ,1'b0},  // 12 R5 back at start
    {1'b1,1'b0,1'b1,6'd13,1'b0},  // 13
    {1'b1,1'b0,1'b1,6'd13,1'b0},  // 14 R6 repeat first step
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 15
    {1'b1,1'b0,1'b1,6'd3 ,1'b1},  // 16 R6 opens
    {1'b0,1'b1,1'b0,6'd0 ,1'b0},  // 17 R9
    {1'b1,1'b0,1'b0,6'd13,1'b0},  // 18 R7 left 13
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 19
    {1'b1,1'b0,1'b1,6'd3 ,1'b0},  // 20 R7 must not open
    {1'b1,1'b0,1'b1,6'd13,1'b0},  // 21
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 22
    {1'b1,1'b0,1'b1,6'd13,1'b0},  // 23 R6 from third state
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 24
    {1'b1,1'b0,1'b1,6'd3 ,1'b1},  // 25 R6 opens
    {1'b1,1'b1,1'b1,6'd13,1'b0},  // 26 R9 relock beats strobe
    {1'b1,1'b0,1'b0,6'd22,1'b0},  // 27
    {1'b1,1'b0,1'b1,6'd3 ,1'b0},  // 28 R9 strobe was dropped
    {1'b1,1'b0,1'b1,6'd13,1'b0},  // 29
    {1'b1,1'b0,1'b1,6'd22,1'b0},  // 30 R5 wrong second
    {1'b1,1'b0,1'b1,6'd3 ,1'b0}   // 31 R5 must not open
  };

  task automatic check(input string req, input logic exp);
    n_checks++;
    if (unlocked !== exp) begin
      n_fails++;
      $display("FAIL %s: unlocked=%b expected=%b at %0t", req, unlocked, exp, $time);
    end
  endtask

  task automatic apply(input logic v, input logic rl, input logic d, input logic [5:0] val);
    op_valid = v; relock = rl; op_dir = d; op_value = val;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; relock = 1'b0;
  endtask

  initial begin
    rst = 1'b1; op_valid = 1'b0; op_dir = 1'b0; op_value = '0; relock = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6:1]);
      check($sformatf("vector %0d", i), VEC[i][0]);
    end

    // R1: reset mid-sequence discards progress
    apply(1'b0, 1'b1, 1'b0, 6'd0);
    apply(1'b1, 1'b0, 1'b1, 6'd13);
    apply(1'b1, 1'b0, 1'b0, 6'd22);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    apply(1'b1, 1'b0, 1'b1, 6'd3);
    check("R1 reset mid-sequence", 1'b0);

    // R1: reset while open
    apply(1'b1, 1'b0, 1'b1, 6'd13);
    apply(1'b1, 1'b0, 1'b0, 6'd22);
    apply(1'b1, 1'b0, 1'b1, 6'd3);
    check("R2 reopen", 1'b1);
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset while open", 1'b0);

    // R3: idle cycles keep the lock closed and R4 holds partial progress
    apply(1'b1, 1'b0, 1'b1, 6'd13);
    repeat (4) apply(1'b0, 1'b0, 1'b0, 6'd22);
    check("R3 partial stays closed", 1'b0);
    apply(1'b1, 1'b0, 1'b0, 6'd22);
    apply(1'b1, 1'b0, 1'b1, 6'd3);
    check("R4 progress held across idle cycles", 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule